// File: doc/BRIEF.md
# LIN Slave Frame Handler

This block is the protocol engine of a LIN slave node that owns two 8-bit routing registers and a five-flag error register. It watches the synchronised receive line for a break, a delimiter and a 0x55 sync byte. The sync byte sets the bit time used for the rest of that frame. It then takes the protected identifier and acts on one of two identifiers picked by a three-level select input. On the write identifier it takes two data bytes and a checksum, and commits both routing registers only when the checksum matches. On the read identifier it answers on its transmit line with five bytes: the error register, both routing registers, a constant 0xFF and a checksum.

The transmit line is meant to drive a bus transceiver, and the receive line carries the wired-AND bus level. The block therefore reads back every bit it sends and stops as soon as the bus disagrees. Faults set sticky flags that stay until a read response completes without error. The nominal bit time is a parameter given in clock cycles.

Top module: `lin_slave_node`

## Requirements
- R1: While reset is asserted and right after it is released, txd is 1, route_a and route_b are 0x00, err_flags is 0x00 and route_upd is 0.
- R2: A frame starts only when rxd stays low for at least BREAK_BITS nominal bit times. Shorter low pulses change no output, and a following frame is still received.
- R3: The span from the first to the fifth falling edge of the sync byte must lie within ±TOL_PCT % of 8 nominal bit times. Outside that window, err_flags bit 4 is set and the frame is dropped. Inside it, the span divided by 8 is the bit time for the rest of the frame, for both receive and transmit.
- R4: as0_sel selects the identifier pair: 2'b00 selects write 0x08 / read 0x27, 2'b01 selects write 0x0A / read 0x29, and 2'b10 or 2'b11 selects write 0x1C / read 0x2B. A correctly protected identifier outside the selected pair is ignored, and no output changes.
- R5: Protected identifier bit 6 must equal id0^id1^id2^id4 and bit 7 must equal the inverse of id1^id3^id4^id5, where id5..id0 are bits 5..0. On a mismatch, err_flags bit 1 is set and the frame is dropped.
- R6: Bytes are sent as 8N1, LSB first. On a write frame whose checksum matches, route_a takes the first data byte and route_b takes the second, and route_upd pulses for exactly one cycle. The routing registers change at no other time.
- R7: The checksum is the inverted 8-bit sum of the data bytes with end-around carry. On a write checksum mismatch, err_flags bit 2 is set and the routing registers are left unchanged.
- R8: A read response starts at least one bit time after the identifier stop bit. It sends {3'b000, error flags}, route_a, route_b, 0xFF and the checksum of those four bytes, with no gaps between the bytes.
- R9: If the bus level sampled mid-bit differs from the bit being sent, err_flags bit 3 is set, transmission stops and txd returns to 1.
- R10: A frame that is not finished within 1.4 × (34 + 10 × (N + 1)) nominal bit times from the start of the break sets err_flags bit 0 and is dropped. N is 2 for a write frame; N is 4 for a read frame or while the identifier is still unknown.
- R11: Completing a read response clears all error flags after the checksum byte. err_flags bits 7..5 always read 0.
- R12: txd is 1 whenever the block is not sending a response byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Bus receive level (asynchronous, synchronised inside) |
| as0_sel | input | 2 | Three-level identifier select: 00 low, 01 open, 1x high |
| txd | output | 1 | Transmit line to the bus driver, idle 1 |
| route_upd | output | 1 | One-cycle pulse when the routing registers are committed |
| route_a | output | 8 | First routing register |
| route_b | output | 8 | Second routing register |
| err_flags | output | 8 | Error register: bit4 sync, bit3 readback, bit2 checksum, bit1 parity, bit0 timeout |

## Verification
The assertions check several rules on every cycle. route_upd is a single-cycle pulse and the routing registers hold between pulses. txd stays high outside a response. Error flags fall only on the cycle a read response completes. The bit time in use lies inside the sync tolerance window, and the frame timer never passes its read limit. The bench scenarios are needed for the rest: the value of every response byte and its checksum, the commit-or-reject decision on the write checksum, each error source, identifier filtering, and reception at non-nominal bit rates.

// File: rtl/lin_slave_node.sv
module lin_slave_node #(
  parameter int unsigned CLK_PER_BIT   = 2604,
  parameter int unsigned BREAK_BITS    = 11,
  parameter int unsigned TOL_PCT       = 15,
  parameter int unsigned WR_DATA_BYTES = 2,
  parameter int unsigned RD_DATA_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic [1:0] as0_sel,
  output logic       txd,
  output logic       route_upd,
  output logic [7:0] route_a,
  output logic [7:0] route_b,
  output logic [7:0] err_flags
);

  localparam int unsigned SPAN_NOM = 8 * CLK_PER_BIT;
  localparam int unsigned SPAN_LO  = SPAN_NOM * (100 - TOL_PCT) / 100;
  localparam int unsigned SPAN_HI  = SPAN_NOM * (100 + TOL_PCT) / 100;
  localparam int unsigned BRK_MIN  = BREAK_BITS * CLK_PER_BIT;
  localparam int unsigned FT_WR    = CLK_PER_BIT * (34 + 10 * (WR_DATA_BYTES + 1)) * 14 / 10;
  localparam int unsigned FT_RD    = CLK_PER_BIT * (34 + 10 * (RD_DATA_BYTES + 1)) * 14 / 10;
  localparam int unsigned TW       = $clog2(FT_RD + 2) + 1;
  localparam int unsigned BW       = $clog2(SPAN_HI / 8 + 2) + 1;

  localparam logic [TW-1:0] SPAN_LO_T = TW'(SPAN_LO);
  localparam logic [TW-1:0] SPAN_HI_T = TW'(SPAN_HI);
  localparam logic [TW-1:0] BRK_MIN_T = TW'(BRK_MIN);
  localparam logic [TW-1:0] FT_WR_T   = TW'(FT_WR);
  localparam logic [TW-1:0] FT_RD_T   = TW'(FT_RD);
  localparam logic [BW-1:0] BIT_LO_T  = BW'(SPAN_LO / 8);
  localparam logic [BW-1:0] BIT_HI_T  = BW'(SPAN_HI / 8);

  typedef enum logic [2:0] {S_IDLE, S_BRK, S_SYNC, S_RXW, S_RX, S_GAP, S_TX, S_HOLD} st_t;
  typedef enum logic [1:0] {P_PID, P_D0, P_D1, P_CK} ph_t;

  function automatic logic [7:0] protect(input logic [5:0] id);
    return {~(id[1] ^ id[3] ^ id[4] ^ id[5]), id[0] ^ id[1] ^ id[2] ^ id[4], id};
  endfunction

  function automatic logic [7:0] cadd(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'b0, s[8]};
  endfunction

  st_t           st;
  ph_t           ph;
  logic [2:0]    rx_s;
  logic          rx, rx_d, fall;
  logic [TW-1:0] cnt, frm, span, lim, bt_ext, half_ext;
  logic [BW-1:0] bit_t;
  logic [2:0]    nfall, byte_no;
  logic [3:0]    bidx, nb;
  logic [7:0]    sh, wb0, wb1, csum, txbyte;
  logic [4:0]    err_q;
  logic          txd_q, upd_q, wr_frm;
  logic          tmo, smp, tx_mid, tx_end, mism, rd_ok, tx_bit, pid_ok;
  logic [5:0]    wr_id, rd_id;

  assign rx        = rx_s[2];
  assign fall      = rx_d & ~rx;
  assign bt_ext    = TW'(bit_t);
  assign half_ext  = TW'(bit_t >> 1);
  assign span      = cnt + TW'(1);
  assign lim       = wr_frm ? FT_WR_T : FT_RD_T;
  assign tmo       = (st != S_IDLE) && (st != S_HOLD) && (frm >= lim);
  assign smp       = (bidx == 4'd0) ? (cnt == half_ext) : (cnt == bt_ext - TW'(1));
  assign tx_mid    = (cnt == half_ext);
  assign tx_end    = (cnt == bt_ext - TW'(1));
  assign mism      = tx_mid && (rx != txd_q);
  assign rd_ok     = (st == S_TX) && !tmo && !mism && tx_end && (bidx == 4'd9) && (byte_no == 3'd4);
  assign pid_ok    = (sh == protect(sh[5:0]));
  assign wr_id     = as0_sel[1] ? 6'h1C : (as0_sel[0] ? 6'h0A : 6'h08);
  assign rd_id     = as0_sel[1] ? 6'h2B : (as0_sel[0] ? 6'h29 : 6'h27);
  assign nb        = bidx + 4'd1;

  always_comb begin
    case (byte_no)
      3'd0:    txbyte = {3'b000, err_q};
      3'd1:    txbyte = route_a;
      3'd2:    txbyte = route_b;
      3'd3:    txbyte = 8'hFF;
      default: txbyte = ~csum;
    endcase
    if (nb >= 4'd9) tx_bit = 1'b1;
    else            tx_bit = txbyte[3'(nb - 4'd1)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s <= 3'b111;
      rx_d <= 1'b1;
    end else begin
      rx_s <= {rx_s[1:0], rxd};
      rx_d <= rx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= P_PID;
      cnt     <= '0;
      frm     <= '0;
      bit_t   <= BW'(CLK_PER_BIT);
      nfall   <= '0;
      bidx    <= '0;
      byte_no <= '0;
      sh      <= '0;
      wb0     <= '0;
      wb1     <= '0;
      csum    <= '0;
      err_q   <= '0;
      txd_q   <= 1'b1;
      upd_q   <= 1'b0;
      wr_frm  <= 1'b0;
      route_a <= '0;
      route_b <= '0;
    end else begin
      upd_q <= 1'b0;
      if (st != S_IDLE && st != S_HOLD) frm <= frm + TW'(1);
      if (tmo) begin
        err_q[0] <= 1'b1;
        txd_q    <= 1'b1;
        st       <= S_HOLD;
      end else begin
        case (st)
          S_IDLE: if (fall) begin
            st     <= S_BRK;
            cnt    <= '0;
            frm    <= '0;
            ph     <= P_PID;
            wr_frm <= 1'b0;
          end
          S_BRK: begin
            cnt <= cnt + TW'(1);
            if (rx) begin
              st    <= (cnt >= BRK_MIN_T - TW'(1)) ? S_SYNC : S_IDLE;
              nfall <= '0;
            end
          end
          S_SYNC: begin
            cnt <= cnt + TW'(1);
            if (fall) begin
              nfall <= nfall + 3'd1;
              if (nfall == 3'd0) cnt <= '0;
              if (nfall == 3'd4) begin
                if (span < SPAN_LO_T || span > SPAN_HI_T) begin
                  err_q[4] <= 1'b1;
                  st       <= S_HOLD;
                end else begin
                  bit_t <= BW'(span >> 3);
                  st    <= S_RXW;
                end
              end
            end else if (nfall != 3'd0 && cnt > SPAN_HI_T) begin
              err_q[4] <= 1'b1;
              st       <= S_HOLD;
            end
          end
          S_RXW: if (fall) begin
            st   <= S_RX;
            cnt  <= '0;
            bidx <= '0;
          end
          S_RX: begin
            cnt <= cnt + TW'(1);
            if (smp) begin
              cnt <= '0;
              if (bidx == 4'd0) begin
                if (rx) st <= S_RXW;
                else    bidx <= 4'd1;
              end else if (bidx != 4'd9) begin
                sh   <= {rx, sh[7:1]};
                bidx <= nb;
              end else if (!rx) begin
                st <= S_HOLD;
              end else begin
                case (ph)
                  P_PID: begin
                    csum <= '0;
                    if (!pid_ok) begin
                      err_q[1] <= 1'b1;
                      st       <= S_HOLD;
                    end else if (sh[5:0] == wr_id) begin
                      ph     <= P_D0;
                      wr_frm <= 1'b1;
                      st     <= S_RXW;
                    end else if (sh[5:0] == rd_id) begin
                      byte_no <= '0;
                      st      <= S_GAP;
                    end else begin
                      st <= S_HOLD;
                    end
                  end
                  P_D0: begin
                    wb0  <= sh;
                    csum <= cadd(csum, sh);
                    ph   <= P_D1;
                    st   <= S_RXW;
                  end
                  P_D1: begin
                    wb1  <= sh;
                    csum <= cadd(csum, sh);
                    ph   <= P_CK;
                    st   <= S_RXW;
                  end
                  default: begin
                    if (sh == ~csum) begin
                      route_a <= wb0;
                      route_b <= wb1;
                      upd_q   <= 1'b1;
                    end else begin
                      err_q[2] <= 1'b1;
                    end
                    st <= S_HOLD;
                  end
                endcase
              end
            end
          end
          S_GAP: begin
            cnt <= cnt + TW'(1);
            if (tx_end) begin
              cnt   <= '0;
              bidx  <= '0;
              txd_q <= 1'b0;
              st    <= S_TX;
            end
          end
          S_TX: begin
            cnt <= cnt + TW'(1);
            if (mism) begin
              err_q[3] <= 1'b1;
              txd_q    <= 1'b1;
              st       <= S_HOLD;
            end else if (tx_end) begin
              cnt <= '0;
              if (bidx == 4'd9) begin
                if (byte_no == 3'd4) begin
                  err_q <= '0;
                  st    <= S_HOLD;
                end else begin
                  csum    <= cadd(csum, txbyte);
                  byte_no <= byte_no + 3'd1;
                  bidx    <= '0;
                  txd_q   <= 1'b0;
                end
              end else begin
                bidx  <= nb;
                txd_q <= tx_bit;
              end
            end
          end
          default: begin
            txd_q <= 1'b1;
            if (rx) st <= S_IDLE;
          end
        endcase
      end
    end
  end

  assign txd       = txd_q;
  assign route_upd = upd_q;
  assign err_flags = {3'b000, err_q};

  // R6
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_upd |=> !route_upd);

  // R6
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !route_upd |-> ($stable(route_a) && $stable(route_b)));

  // R12
  txd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_TX) |-> txd);

  // R11
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(err_q) & ~err_q)) |-> $past(rd_ok));

  // R3
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX || st == S_GAP || st == S_TX) |-> (bit_t >= BIT_LO_T && bit_t <= BIT_HI_T));

  // R10
  frame_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && st != S_HOLD) |-> (frm <= FT_RD_T));

endmodule

// File: tb/lin_slave_node_tb.sv
module lin_slave_node_tb;
  localparam int NOM = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_tx = 1'b1;
  logic [1:0] as0_sel = 2'b00;
  logic       bus, txd, route_upd;
  logic [7:0] route_a, route_b, err_flags;
  int nchk = 0, nfail = 0, upd_cnt = 0;

  assign bus = m_tx & txd;
  always #5 clk = ~clk;

  lin_slave_node #(.CLK_PER_BIT(NOM)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(bus), .as0_sel(as0_sel), .txd(txd),
    .route_upd(route_upd), .route_a(route_a), .route_b(route_b), .err_flags(err_flags));

  always @(posedge clk) if (rst_n && route_upd) upd_cnt <= upd_cnt + 1;

  function automatic logic [7:0] pidf(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = !(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  function automatic logic [7:0] cks(input logic [7:0] b0, input logic [7:0] b1,
                                     input logic [7:0] b2, input logic [7:0] b3, input int n);
    int s;
    s = b0 + b1; if (s > 255) s -= 255;
    if (n > 2) begin
      s += b2; if (s > 255) s -= 255;
      s += b3; if (s > 255) s -= 255;
    end
    return ~(8'(s));
  endfunction

  function automatic logic [5:0] wid(input logic [1:0] a);
    return a[1] ? 6'h1C : (a[0] ? 6'h0A : 6'h08);
  endfunction
  function automatic logic [5:0] rid(input logic [1:0] a);
    return a[1] ? 6'h2B : (a[0] ? 6'h29 : 6'h27);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    m_tx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int bt);
    drive(1'b0, bt);
    for (int i = 0; i < 8; i++) drive(b[i], bt);
    drive(1'b1, bt);
  endtask

  task automatic send_header(input logic [7:0] pid, input int bt);
    drive(1'b0, 13 * bt);
    drive(1'b1, bt);
    send_byte(8'h55, bt);
    send_byte(pid, bt);
  endtask

  task automatic recv_byte(output logic [7:0] b, input int bt);
    while (bus === 1'b1) @(negedge clk);
    repeat (bt / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (bt) @(negedge clk);
      b[i] = bus;
    end
    repeat (bt) @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] a, input int bt, input logic [7:0] d0,
                          input logic [7:0] d1, input logic good);
    logic [7:0] c;
    as0_sel = a;
    c = cks(d0, d1, 8'h00, 8'h00, 2);
    send_header(pidf(wid(a)), bt);
    send_byte(d0, bt);
    send_byte(d1, bt);
    send_byte(good ? c : (c ^ 8'h5A), bt);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input logic [1:0] a, input int bt, input logic [7:0] st_exp,
                         input logic [7:0] ea, input logic [7:0] eb);
    logic [7:0] r [5];
    as0_sel = a;
    send_header(pidf(rid(a)), bt);
    for (int i = 0; i < 5; i++) recv_byte(r[i], bt);
    repeat (2 * bt) @(negedge clk);
    chk("R8 status byte", r[0], st_exp);
    chk("R8 route_a byte", r[1], ea);
    chk("R8 route_b byte", r[2], eb);
    chk("R8 stuffing byte", r[3], 8'hFF);
    chk("R8 checksum byte", r[4], cks(st_exp, ea, eb, 8'hFF, 4));
    chk("R11 flags cleared after read", err_flags, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] ea, eb, d0, d1;
    logic [1:0] a;
    int bt, u0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    // R1 during reset
    chk("R1 txd in reset", txd, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 txd", txd, 1'b1);
    chk("R1 route_a", route_a, 8'h00);
    chk("R1 route_b", route_b, 8'h00);
    chk("R1 err_flags", err_flags, 8'h00);
    chk("R1 route_upd", route_upd, 1'b0);

    ea = 8'h00; eb = 8'h00;
    for (int k = 0; k < 8; k++) begin
      a  = 2'($urandom % 4);
      bt = 15 + int'($urandom % 4);
      d0 = 8'($urandom);
      d1 = 8'($urandom);
      u0 = upd_cnt;
      do_write(a, bt, d0, d1, 1'b1);
      ea = d0; eb = d1;
      chk("R6 R4 R3 route_a after write", route_a, ea);
      chk("R6 route_b after write", route_b, eb);
      chk("R6 single update pulse", upd_cnt - u0, 1);
      do_read(a, bt, 8'h00, ea, eb);
    end

    // R2: short low pulse is ignored, next frame still accepted
    drive(1'b0, 5 * NOM);
    drive(1'b1, 20 * NOM);
    chk("R2 short low no error", err_flags, 8'h00);
    chk("R2 short low route_a kept", route_a, ea);
    do_write(2'b00, NOM, 8'hA5, 8'h3C, 1'b1);
    ea = 8'hA5; eb = 8'h3C;
    chk("R2 frame after short low", route_a, ea);

    // R4: foreign write identifier ignored
    u0 = upd_cnt;
    as0_sel = 2'b00;
    send_header(pidf(6'h0A), NOM);
    send_byte(8'h11, NOM); send_byte(8'h22, NOM); send_byte(cks(8'h11, 8'h22, 0, 0, 2), NOM);
    repeat (4) @(negedge clk);
    chk("R4 foreign id route_a", route_a, ea);
    chk("R4 foreign id no pulse", upd_cnt - u0, 0);
    chk("R4 foreign id no flag", err_flags, 8'h00);

    // R5: parity error
    send_header(pidf(wid(2'b01)) ^ 8'h40, NOM);
    repeat (4 * NOM) @(negedge clk);
    as0_sel = 2'b01;
    chk("R5 parity flag", err_flags, 8'h02);
    do_read(2'b01, NOM, 8'h02, ea, eb);

    // R7: bad write checksum
    do_write(2'b10, NOM, 8'h77, 8'h88, 1'b0);
    chk("R7 checksum flag", err_flags, 8'h04);
    chk("R7 route_a unchanged", route_a, ea);
    chk("R7 route_b unchanged", route_b, eb);
    do_read(2'b10, NOM, 8'h04, ea, eb);

    // R3: sync far too slow
    do_write(2'b00, 20, 8'h3C, 8'h5A, 1'b1);
    repeat (4 * NOM) @(negedge clk);
    chk("R3 sync flag", err_flags, 8'h10);
    chk("R3 route_a unchanged", route_a, ea);
    do_read(2'b00, NOM, 8'h10, ea, eb);

    // R10: write frame stalls after first data byte
    as0_sel = 2'b01;
    send_header(pidf(wid(2'b01)), NOM);
    send_byte(8'h42, NOM);
    drive(1'b1, 1000);
    chk("R10 timeout flag", err_flags, 8'h01);
    chk("R10 route_a unchanged", route_a, ea);
    do_read(2'b01, NOM, 8'h01, ea, eb);

    // R9: bus conflict during response
    as0_sel = 2'b10;
    send_header(pidf(rid(2'b10)), NOM);
    while (txd === 1'b1) @(negedge clk);
    drive(1'b0, 12 * NOM);
    chk("R12 txd released after conflict", txd, 1'b1);
    drive(1'b1, 20 * NOM);
    chk("R9 readback flag", err_flags, 8'h08);
    do_read(2'b10, NOM, 8'h08, ea, eb);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule